// File: doc/BRIEF.md
# Modulo-Scheduled Hardware Loop Sequencer

This block sequences nested counted loops without any branch instructions. Software first loads loop parameters into one of a small set of parameter contexts: an iteration count and an initiation interval, the spacing in cycles between successive iteration starts. A command then enters a loop on a chosen context. The running loop's counter advances on a fixed interval timer, and each step starts a new loop body. The step to the next iteration costs no extra cycles, so bodies longer than the interval simply overlap. For example, 18-cycle bodies issued every 7 cycles keep three in flight.

If a loop is already running when a new one is entered, the running loop is suspended onto a hardware stack. Its counter stays visible on a dedicated output so that address generators can keep indexing with the enclosing loop's iteration number. When the inner loop ends, a done pulse is raised and the suspended loop resumes on the following cycle. It carries on exactly where it stopped.

Top module: `hwl_loop_unit`

## Requirements
- R1: After reset, no loop is active, both counter outputs read 0, and body_start_o, loop_done_o and err_o are low.
- R2: A configuration write sets one context's trip count (legal 1 to 255) and interval (legal 1 to 15). A write carrying a zero in either field leaves that context unchanged. Contexts reset to trip 1, interval 1.
- R3: An enter command accepted in cycle t makes the loop active in cycle t+1, with cur_cnt_o = 0 and body_start_o high.
- R4: While a loop runs with interval N, body_start_o rises every N cycles, and cur_cnt_o increases by exactly one at each new body start. With N = 1, bodies start in every cycle with no gap.
- R5: loop_done_o pulses for one cycle in the last cycle of the final iteration's interval, which is trip*N-1 cycles after the first body start.
- R6: With no suspended loop, the unit goes idle (active_o low, cur_cnt_o 0) in the cycle after loop_done_o.
- R7: Entering while a loop is active suspends that loop onto the stack. In the next cycle outer_cnt_o equals the suspended loop's counter. outer_cnt_o reads 0 when the stack is empty.
- R8: The cycle after an inner loop's done pulse, the suspended loop is active again with its saved counter. It does not repeat a body-start pulse, and it finishes its interval from the saved timer position.
- R9: The stack holds 4 suspended loops. An enter while four are suspended and one runs is ignored: the running loop continues undisturbed, and err_o is high for one cycle in the following cycle.
- R10: Each context keeps its own trip count and interval, and a nested loop runs with the parameters of the context it was entered on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Context parameter write strobe |
| cfg_ctx_i | input | 2 | Context written |
| cfg_trip_i | input | 8 | Iteration count for the written context |
| cfg_ii_i | input | 4 | Initiation interval for the written context |
| enter_i | input | 1 | Enter a loop on enter_ctx_i |
| enter_ctx_i | input | 2 | Context of the loop being entered |
| cur_cnt_o | output | 8 | Iteration index of the running loop |
| outer_cnt_o | output | 8 | Iteration index of the most recently suspended loop |
| active_o | output | 1 | A loop is running |
| body_start_o | output | 1 | A new loop body starts this cycle |
| loop_done_o | output | 1 | Last cycle of the running loop |
| err_o | output | 1 | Previous enter was refused because the stack was full |

## Verification
The bench sweeps trip counts and intervals, including interval 1 and 15 and trip counts 1 and 255. A timer off by one would shift every body start, and a done pulse tied to the final body start rather than the end of its interval would fire early. A nested run places the inner entry on the outer loop's body-start cycle. On resume, a design that restored the loop with a fresh body-start pulse would issue a duplicate body, and one that dropped the saved timer would misplace the outer loop's remaining starts. Zero-field configuration writes are checked through the run length they would have changed. An over-deep entry is checked by confirming that the running loop did not restart and that the refusal flag lasts one cycle.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  localparam int HWL_N_CTX = 4;
  localparam int HWL_DEPTH = 4;
  localparam int HWL_CNT_W = 8;
  localparam int HWL_II_W  = 4;
endpackage

// File: rtl/hwl_ctx_file.sv
module hwl_ctx_file #(
  parameter int N_CTX = hwl_pkg::HWL_N_CTX,
  parameter int CNT_W = hwl_pkg::HWL_CNT_W,
  parameter int II_W  = hwl_pkg::HWL_II_W,
  localparam int CTX_W = $clog2(N_CTX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTX_W-1:0] wsel_i,
  input  logic [CNT_W-1:0] trip_i,
  input  logic [II_W-1:0]  ii_i,
  input  logic [CTX_W-1:0] rsel_i,
  output logic [CNT_W-1:0] trip_o,
  output logic [II_W-1:0]  ii_o
);
  logic [CNT_W-1:0] trip_q [N_CTX];
  logic [II_W-1:0]  ii_q   [N_CTX];
  logic             wr_ok;

  assign wr_ok = we_i && (trip_i != '0) && (ii_i != '0);

  for (genvar g = 0; g < N_CTX; g++) begin : g_ctx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        trip_q[g] <= CNT_W'(1);
        ii_q[g]   <= II_W'(1);
      end else if (wr_ok && wsel_i == CTX_W'(g)) begin
        trip_q[g] <= trip_i;
        ii_q[g]   <= ii_i;
      end
    end
  end

  assign trip_o = trip_q[rsel_i];
  assign ii_o   = ii_q[rsel_i];

  AST_CTX_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o != '0) && (ii_o != '0)); // R2
endmodule

// File: rtl/hwl_stack.sv
module hwl_stack #(
  parameter int DEPTH = hwl_pkg::HWL_DEPTH,
  parameter int W     = 14,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp_q;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SP_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (push_i) sp_q <= sp_q + SP_W'(1);
    else if (pop_i)  sp_q <= sp_q - SP_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem[g] <= '0;
      else if (push_i && sp_q == SP_W'(g))  mem[g] <= din_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sp_q == SP_W'(i + 1)) top_o = mem[i];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R8
endmodule

// File: rtl/hwl_step.sv
module hwl_step #(
  parameter int CNT_W = hwl_pkg::HWL_CNT_W,
  parameter int II_W  = hwl_pkg::HWL_II_W
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [II_W-1:0]  tmr_i,
  input  logic [CNT_W-1:0] trip_i,
  input  logic [II_W-1:0]  ii_i,
  output logic             slot_end_o,
  output logic             last_iter_o,
  output logic [CNT_W-1:0] cnt_inc_o,
  output logic [II_W-1:0]  tmr_inc_o
);
  assign slot_end_o  = (tmr_i == ii_i - II_W'(1));
  assign last_iter_o = (cnt_i == trip_i - CNT_W'(1));
  assign cnt_inc_o   = cnt_i + CNT_W'(1);
  assign tmr_inc_o   = tmr_i + II_W'(1);
endmodule

// File: rtl/hwl_loop_unit.sv
module hwl_loop_unit #(
  parameter int N_CTX = hwl_pkg::HWL_N_CTX,
  parameter int DEPTH = hwl_pkg::HWL_DEPTH,
  parameter int CNT_W = hwl_pkg::HWL_CNT_W,
  parameter int II_W  = hwl_pkg::HWL_II_W,
  localparam int CTX_W = $clog2(N_CTX),
  localparam int FRM_W = CTX_W + CNT_W + II_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CTX_W-1:0] cfg_ctx_i,
  input  logic [CNT_W-1:0] cfg_trip_i,
  input  logic [II_W-1:0]  cfg_ii_i,
  input  logic             enter_i,
  input  logic [CTX_W-1:0] enter_ctx_i,
  output logic [CNT_W-1:0] cur_cnt_o,
  output logic [CNT_W-1:0] outer_cnt_o,
  output logic             active_o,
  output logic             body_start_o,
  output logic             loop_done_o,
  output logic             err_o
);
  logic             act_q, fresh_q, err_q;
  logic [CTX_W-1:0] ctx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [II_W-1:0]  tmr_q;

  logic [CNT_W-1:0] trip;
  logic [II_W-1:0]  ii;
  logic             slot_end, last_iter;
  logic [CNT_W-1:0] cnt_inc;
  logic [II_W-1:0]  tmr_inc;

  logic             stk_empty, stk_full, push, pop, enter_ok, finish;
  logic [FRM_W-1:0] stk_top;

  hwl_ctx_file #(.N_CTX(N_CTX), .CNT_W(CNT_W), .II_W(II_W)) u_ctx (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .wsel_i(cfg_ctx_i), .trip_i(cfg_trip_i), .ii_i(cfg_ii_i),
    .rsel_i(ctx_q), .trip_o(trip), .ii_o(ii)
  );

  hwl_step #(.CNT_W(CNT_W), .II_W(II_W)) u_step (
    .cnt_i(cnt_q), .tmr_i(tmr_q), .trip_i(trip), .ii_i(ii),
    .slot_end_o(slot_end), .last_iter_o(last_iter),
    .cnt_inc_o(cnt_inc), .tmr_inc_o(tmr_inc)
  );

  // enter has priority over the running loop's own step in the same cycle
  assign enter_ok = enter_i && !(act_q && stk_full);
  assign finish   = act_q && !enter_ok && slot_end && last_iter;
  assign push     = enter_ok && act_q;
  assign pop      = finish && !stk_empty;

  hwl_stack #(.DEPTH(DEPTH), .W(FRM_W)) u_stk (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop), .din_i({ctx_q, cnt_q, tmr_q}),
    .top_o(stk_top), .empty_o(stk_empty), .full_o(stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      fresh_q <= 1'b0;
      err_q   <= 1'b0;
      ctx_q   <= '0;
      cnt_q   <= '0;
      tmr_q   <= '0;
    end else begin
      err_q <= enter_i && !enter_ok;
      if (enter_ok) begin
        act_q   <= 1'b1;
        fresh_q <= 1'b1;
        ctx_q   <= enter_ctx_i;
        cnt_q   <= '0;
        tmr_q   <= '0;
      end else if (act_q) begin
        if (finish) begin
          fresh_q <= 1'b0;
          if (pop) begin
            {ctx_q, cnt_q, tmr_q} <= stk_top;
          end else begin
            act_q <= 1'b0;
            cnt_q <= '0;
            tmr_q <= '0;
          end
        end else if (slot_end) begin
          fresh_q <= 1'b1;
          cnt_q   <= cnt_inc;
          tmr_q   <= '0;
        end else begin
          fresh_q <= 1'b0;
          tmr_q   <= tmr_inc;
        end
      end
    end
  end

  assign cur_cnt_o    = cnt_q;
  assign outer_cnt_o  = stk_empty ? '0 : stk_top[II_W +: CNT_W];
  assign active_o     = act_q;
  assign body_start_o = fresh_q;
  assign loop_done_o  = finish;
  assign err_o        = err_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (!body_start_o && !loop_done_o && cur_cnt_o == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active_o) && body_start_o && !$past(enter_i))
      |-> cur_cnt_o == $past(cur_cnt_o) + CNT_W'(1)); // R4
  AST_DONE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_done_o && outer_cnt_o == '0 && stk_empty) |=> !active_o); // R6
  AST_PUSH_SHOWS_OUTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_i && active_o && !stk_full) |=> outer_cnt_o == $past(cur_cnt_o)); // R7
  AST_REFUSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_i && active_o && stk_full) |=> err_o); // R9
endmodule

// File: tb/hwl_loop_unit_test.sv
`timescale 1ns/1ps
module hwl_loop_unit_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_ctx = '0;
  logic [7:0] cfg_trip = '0;
  logic [3:0] cfg_ii = '0;
  logic       enter = 1'b0;
  logic [1:0] enter_ctx = '0;
  logic [7:0] cur_cnt, outer_cnt;
  logic       active, body_start, loop_done, err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  hwl_loop_unit uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_ctx_i(cfg_ctx), .cfg_trip_i(cfg_trip), .cfg_ii_i(cfg_ii),
    .enter_i(enter), .enter_ctx_i(enter_ctx),
    .cur_cnt_o(cur_cnt), .outer_cnt_o(outer_cnt), .active_o(active),
    .body_start_o(body_start), .loop_done_o(loop_done), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // each cycle: inputs set at negedge, outputs sampled 1 ns later
  task automatic nx();
    @(negedge clk);
    cfg_we = 1'b0;
    enter  = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    cfg_we = 1'b0;
    enter  = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input int c, input int t, input int i);
    nx();
    cfg_we = 1'b1; cfg_ctx = 2'(c); cfg_trip = 8'(t); cfg_ii = 4'(i);
  endtask

  task automatic run_single(input int c, input int trip, input int ii);
    nx();
    enter = 1'b1; enter_ctx = 2'(c);
    for (int j = 0; j <= trip * ii; j++) begin
      nx();
      #1;
      if (j == 0) chk("R3 first body", int'(body_start), 1);
      chk("R4 body_start", int'(body_start), (j < trip * ii && j % ii == 0) ? 1 : 0);
      chk("R4 cur_cnt", int'(cur_cnt), (j < trip * ii) ? j / ii : 0);
      chk("R5 loop_done", int'(loop_done), (j == trip * ii - 1) ? 1 : 0);
      chk("R6 active", int'(active), (j < trip * ii) ? 1 : 0);
    end
  endtask

  initial begin
    #1_600_000;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int trips [4] = '{1, 2, 3, 5};
    int iis   [5] = '{1, 2, 3, 7, 15};
    do_reset();
    #1;
    // R1 reset state
    chk("R1 active", int'(active), 0);
    chk("R1 cur_cnt", int'(cur_cnt), 0);
    chk("R1 outer_cnt", int'(outer_cnt), 0);
    chk("R1 body_start", int'(body_start), 0);
    chk("R1 loop_done", int'(loop_done), 0);
    chk("R1 err", int'(err), 0);

    // R2 reset context values: trip 1, interval 1
    run_single(1, 1, 1);

    // R4 R5 R6 sweep
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 5; b++) begin
        wr((a + b) % 4, trips[a], iis[b]);
        run_single((a + b) % 4, trips[a], iis[b]);
      end
    wr(1, 255, 1);
    run_single(1, 255, 1);
    wr(3, 2, 15);
    run_single(3, 2, 15);

    // R2 zero fields ignored
    wr(2, 3, 2);
    wr(2, 0, 5);
    wr(2, 5, 0);
    run_single(2, 3, 2);

    // R7 R8 R10 nesting: outer ctx0 trip3 ii4, inner ctx1 trip2 ii3
    wr(0, 3, 4);
    wr(1, 2, 3);
    nx();
    enter = 1'b1; enter_ctx = 2'd0;
    for (int j = 1; j <= 20; j++) begin
      int e_cur, e_bs, e_out, e_done, e_act;
      nx();
      if (j == 5) begin enter = 1'b1; enter_ctx = 2'd1; end
      #1;
      e_act = 1; e_done = 0; e_out = 0;
      if (j <= 4) begin
        e_cur = 0; e_bs = (j == 1);
      end else if (j == 5) begin
        e_cur = 1; e_bs = 1;
      end else if (j <= 11) begin
        e_cur = (j - 6) / 3; e_bs = ((j - 6) % 3 == 0); e_out = 1; e_done = (j == 11);
      end else if (j <= 19) begin
        e_cur = 1 + (j - 12) / 4; e_bs = (j == 16); e_done = (j == 19);
      end else begin
        e_cur = 0; e_bs = 0; e_act = 0;
      end
      chk("R7 outer_cnt", int'(outer_cnt), e_out);
      chk("R10 R8 cur_cnt", int'(cur_cnt), e_cur);
      chk("R8 body_start", int'(body_start), e_bs);
      chk("R5 loop_done nested", int'(loop_done), e_done);
      chk("R8 active", int'(active), e_act);
    end

    // R9 stack full
    wr(3, 255, 15);
    for (int k = 0; k < 6; k++) begin
      nx();
      enter = 1'b1; enter_ctx = 2'd3;
      #1;
      chk("R9 no err while filling", int'(err), 0);
    end
    nx();
    #1;
    chk("R9 err raised", int'(err), 1);
    chk("R9 running loop not restarted", int'(body_start), 0);
    chk("R9 cur_cnt kept", int'(cur_cnt), 0);
    chk("R9 still active", int'(active), 1);
    nx();
    #1;
    chk("R9 err one cycle", int'(err), 0);

    do_reset();
    #1;
    chk("R1 active after reset", int'(active), 0);
    chk("R1 outer after reset", int'(outer_cnt), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule